// File: doc/BRIEF.md
# Aligned Block Loader for a Two-Dimensional Module Array

This sequencer fills an array of small memory modules, arranged as ROWS by COLS, from a main memory that holds an image in scan-line order. Each main-memory word carries LANES pixels, starting at the pixel whose scan-line index is the word address. A client gives the upper-left corner of a block whose row is a multiple of ROWS and whose column is a multiple of COLS. The loader then reads the ROWS·COLS/LANES words that cover the block, one read per cycle. It writes each returned word into LANES neighbouring modules of one module row, and every module written in that load uses the same local address.

Module selection uses two separate enable vectors, one per module row and one per module column. A module writes only when its row enable and its column enable are both high. Module column q takes its pixel from data lane q mod LANES, so several columns share each lane. The FSM has three named states. LD_IDLE waits for start. An accepted start moves it to LD_ISSUE, which issues one read per cycle and leaves on the last read. LD_FLUSH covers the final write and always returns to LD_IDLE. A start in LD_IDLE whose origin is not aligned stays in LD_IDLE and raises an error pulse.

Top module: `blk_loader`

## Requirements
- R1: After reset, busy, done, align_err, mem_rd and every module enable are low.
- R2: A start in idle with org_row not a multiple of ROWS, or org_col not a multiple of COLS, raises align_err for exactly the next cycle. It issues no read and no write, and busy stays low.
- R3: An aligned start (i,j) issues exactly ROWS·COLS/LANES reads on consecutive cycles, beginning the cycle after start is sampled. Read number n has address (i+k)·IMG_COLS + j + l·LANES, where k = n div (COLS/LANES) and l = n mod (COLS/LANES), so l runs fastest.
- R4: The word returned for read n is written in the cycle after that read. Data lane w (bits w·8 up to w·8+7) goes to module column l·LANES+w of module row k.
- R5: During a write exactly one row-enable bit (bit k) is high, and exactly the LANES column-enable bits l·LANES through l·LANES+LANES−1 are high. No enable is high in any other cycle.
- R6: During every write of a load, mod_addr equals (i div ROWS)·(IMG_COLS/COLS) + (j div COLS).
- R7: busy is high for exactly ROWS·COLS/LANES+1 cycles, from the cycle after the accepted start through the last write. done is high for the single cycle after that.
- R8: A start, aligned or not, that arrives while busy is ignored. It raises no align_err, and it changes neither the read sequence nor the number of reads.
- R9: After every aligned block of the image has been loaded, module (p,q) at local address L holds the image pixel at row (L div (IMG_COLS/COLS))·ROWS+p, column (L mod (IMG_COLS/COLS))·COLS+q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load request, sampled in idle only |
| org_row | input | $clog2(IMG_ROWS) | Block origin row |
| org_col | input | $clog2(IMG_COLS) | Block origin column |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse after the last write |
| align_err | output | 1 | One-cycle pulse for a rejected origin |
| mem_addr | output | $clog2(IMG_ROWS·IMG_COLS) | Main-memory pixel address |
| mem_rd | output | 1 | Main-memory read strobe |
| mem_rdata | input | LANES·8 | Main-memory data, one cycle after the read |
| mod_we_row | output | ROWS | Row write enables |
| mod_we_col | output | COLS | Column write enables |
| mod_addr | output | local address width | Common local write address |
| mod_wdata | output | LANES·8 | Write data lanes |

## Verification
The bench targets the origin at the bottom-right corner of the image. A loader that adds the row stride incorrectly, or wraps a counter early, writes the wrong pixels or the wrong local address there. It also checks the order of the inner and outer loops. Swapping them would keep the read count correct but put each word in the wrong module row. During a load the bench issues both aligned and misaligned starts. A loader that restarts would repeat addresses, and one that flags the misaligned start would pulse align_err while busy. Misaligned origins in idle must produce no memory activity. Finally, a full sweep of the image shows whether the latency of the enable pipeline matches the one-cycle data return: if it were off by one, each word would land under the wrong enables.

// File: rtl/blk_ld_pkg.sv
package blk_ld_pkg;
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_ISSUE = 2'd1,
        LD_FLUSH = 2'd2
    } ld_state_e;
endpackage

// File: rtl/blk_ld_agen.sv
// Walks the block's word addresses: column group fastest, then module row.
module blk_ld_agen #(
    parameter int ROWS     = 2,
    parameter int COLS     = 4,
    parameter int LANES    = 2,
    parameter int IMG_COLS = 16,
    parameter int AW       = 7,
    parameter int KW       = 1,
    parameter int LW       = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] addr,
    output logic [KW-1:0] k_idx,
    output logic [LW-1:0] l_idx,
    output logic          last
);
    localparam int GROUPS = COLS / LANES;
    localparam logic [KW-1:0] K_END = KW'(ROWS - 1);
    localparam logic [LW-1:0] L_END = LW'(GROUPS - 1);

    logic [AW-1:0] row_base_q;
    logic [KW-1:0] k_q;
    logic [LW-1:0] l_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_base_q <= '0;
            k_q        <= '0;
            l_q        <= '0;
        end else if (clear) begin
            row_base_q <= base;
            k_q        <= '0;
            l_q        <= '0;
        end else if (step) begin
            if (l_q == L_END) begin
                l_q        <= '0;
                k_q        <= k_q + 1'b1;
                row_base_q <= row_base_q + AW'(IMG_COLS);
            end else begin
                l_q <= l_q + 1'b1;
            end
        end
    end

    assign addr  = row_base_q + AW'(l_q) * AW'(LANES);
    assign k_idx = k_q;
    assign l_idx = l_q;
    assign last  = (k_q == K_END) && (l_q == L_END);
endmodule

// File: rtl/blk_ld_steer.sv
// Delays the module selection by the main-memory read latency and decodes it.
module blk_ld_steer #(
    parameter int ROWS  = 2,
    parameter int COLS  = 4,
    parameter int LANES = 2,
    parameter int KW    = 1,
    parameter int LW    = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [KW-1:0]   k_idx,
    input  logic [LW-1:0]   l_idx,
    output logic [ROWS-1:0] we_row,
    output logic [COLS-1:0] we_col
);
    logic          v_q;
    logic [KW-1:0] k_q;
    logic [LW-1:0] l_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= 1'b0;
            k_q <= '0;
            l_q <= '0;
        end else begin
            v_q <= fire;
            k_q <= k_idx;
            l_q <= l_idx;
        end
    end

    for (genvar p = 0; p < ROWS; p++) begin : g_row
        assign we_row[p] = v_q && (k_q == KW'(p));
    end

    for (genvar q = 0; q < COLS; q++) begin : g_col
        assign we_col[q] = v_q && (l_q == LW'(q / LANES));
    end
endmodule

// File: rtl/blk_loader.sv
module blk_loader #(
    parameter int ROWS     = 2,
    parameter int COLS     = 4,
    parameter int LANES    = 2,
    parameter int IMG_ROWS = 8,
    parameter int IMG_COLS = 16,
    parameter int PIX_W    = 8,
    localparam int RW  = $clog2(IMG_ROWS),
    localparam int CW  = $clog2(IMG_COLS),
    localparam int AW  = $clog2(IMG_ROWS * IMG_COLS),
    localparam int LAW = $clog2((IMG_ROWS / ROWS) * (IMG_COLS / COLS)),
    localparam int DW  = LANES * PIX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [RW-1:0]   org_row,
    input  logic [CW-1:0]   org_col,
    output logic            busy,
    output logic            done,
    output logic            align_err,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_rd,
    input  logic [DW-1:0]   mem_rdata,
    output logic [ROWS-1:0] mod_we_row,
    output logic [COLS-1:0] mod_we_col,
    output logic [LAW-1:0]  mod_addr,
    output logic [DW-1:0]   mod_wdata
);
    import blk_ld_pkg::*;

    localparam int KW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int LW = ((COLS / LANES) > 1) ? $clog2(COLS / LANES) : 1;

    ld_state_e      state_q, state_d;
    logic           aligned, accept, reject, last;
    logic           done_q, err_q;
    logic [LAW-1:0] laddr_q;
    logic [AW-1:0]  base;
    logic [KW-1:0]  k_idx;
    logic [LW-1:0]  l_idx;

    assign aligned = ((org_row % ROWS) == 0) && ((org_col % COLS) == 0);
    assign accept  = start && (state_q == LD_IDLE) && aligned;
    assign reject  = start && (state_q == LD_IDLE) && !aligned;
    assign base    = AW'(org_row) * AW'(IMG_COLS) + AW'(org_col);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:  if (accept) state_d = LD_ISSUE;
            LD_ISSUE: if (last)   state_d = LD_FLUSH;
            LD_FLUSH: state_d = LD_IDLE;
            default:  state_d = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            laddr_q <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == LD_FLUSH);
            err_q   <= reject;
            if (accept)
                laddr_q <= LAW'((org_row / ROWS) * (IMG_COLS / COLS) + (org_col / COLS));
        end
    end

    always_comb begin
        busy      = (state_q != LD_IDLE);
        mem_rd    = (state_q == LD_ISSUE);
        done      = done_q;
        align_err = err_q;
        mod_addr  = laddr_q;
        mod_wdata = mem_rdata;
    end

    blk_ld_agen #(
        .ROWS(ROWS), .COLS(COLS), .LANES(LANES), .IMG_COLS(IMG_COLS),
        .AW(AW), .KW(KW), .LW(LW)
    ) u_agen (
        .clk(clk), .rst_n(rst_n), .clear(accept), .step(mem_rd), .base(base),
        .addr(mem_addr), .k_idx(k_idx), .l_idx(l_idx), .last(last)
    );

    blk_ld_steer #(
        .ROWS(ROWS), .COLS(COLS), .LANES(LANES), .KW(KW), .LW(LW)
    ) u_steer (
        .clk(clk), .rst_n(rst_n), .fire(mem_rd), .k_idx(k_idx), .l_idx(l_idx),
        .we_row(mod_we_row), .we_col(mod_we_col)
    );

    // R4
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (|mod_we_row));
    // R5
    one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mod_we_row));
    // R5
    lane_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|mod_we_col) |-> ($countones(mod_we_col) == LANES) && (|mod_we_row));
    // R2
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> !busy && !mem_rd && !(|mod_we_row));
    // R7
    done_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));
    // R6
    laddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mod_addr));
endmodule

// File: tb/blk_loader_test.sv
module blk_loader_test;
    localparam int A   = 2;
    localparam int B   = 4;
    localparam int W   = 2;
    localparam int M   = 8;
    localparam int N   = 16;
    localparam int LG  = B / W;
    localparam int NLD = A * B / W;
    localparam int NBC = N / B;
    localparam int NLA = (M / A) * NBC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] org_row = '0;
    logic [3:0] org_col = '0;
    logic busy, done, align_err, mem_rd;
    logic [6:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic [A-1:0] mod_we_row;
    logic [B-1:0] mod_we_col;
    logic [3:0] mod_addr;
    logic [15:0] mod_wdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] mm [A][B][NLA];

    always #5 clk = ~clk;

    blk_loader uut (
        .clk(clk), .rst_n(rst_n), .start(start), .org_row(org_row), .org_col(org_col),
        .busy(busy), .done(done), .align_err(align_err), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mod_we_row(mod_we_row),
        .mod_we_col(mod_we_col), .mod_addr(mod_addr), .mod_wdata(mod_wdata)
    );

    function automatic logic [7:0] pix(int r, int c);
        return 8'((r * 37 + c * 13 + 7) & 255);
    endfunction

    function automatic logic [15:0] word_at(int a);
        logic [15:0] v = '0;
        for (int w = 0; w < W; w++) v[w*8 +: 8] = pix((a + w) / N, (a + w) % N);
        return v;
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= word_at(int'(mem_addr));

    always @(posedge clk)
        for (int p = 0; p < A; p++)
            for (int q = 0; q < B; q++)
                if (mod_we_row[p] && mod_we_col[q])
                    mm[p][q][mod_addr] <= mod_wdata[(q % W) * 8 +: 8];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_load(input int i, input int j, input int inject);
        int rd_n = 0, wr_n = 0, bz = 0, cyc = 0;
        @(negedge clk);
        start = 1'b1; org_row = 3'(i); org_col = 4'(j);
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < NLD + 6) begin
            chk(!align_err, "R8 no error while busy", align_err, 0);
            if (mem_rd) begin
                int k = rd_n / LG, l = rd_n % LG;
                chk(int'(mem_addr) == (i + k) * N + j + l * W, "R3 read address",
                    mem_addr, (i + k) * N + j + l * W);
                rd_n++;
            end
            if ((|mod_we_row) || (|mod_we_col)) begin
                int k = wr_n / LG, l = wr_n % LG;
                logic [15:0] ew = '0;
                for (int w = 0; w < W; w++) ew[w*8 +: 8] = pix(i + k, j + l * W + w);
                chk(mod_we_row == A'(1 << k), "R5 row enable", mod_we_row, 1 << k);
                chk(mod_we_col == B'(((1 << W) - 1) << (l * W)), "R5 column enable",
                    mod_we_col, ((1 << W) - 1) << (l * W));
                chk(int'(mod_addr) == (i / A) * NBC + j / B, "R6 local address",
                    mod_addr, (i / A) * NBC + j / B);
                chk(mod_wdata == ew, "R4 write data", mod_wdata, ew);
                wr_n++;
            end
            if (busy) bz++;
            if (inject != 0 && cyc == 1) begin
                start = 1'b1;
                org_row = (inject == 1) ? 3'((i + A) % M) : 3'(i + 1);
                org_col = 4'(j);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done, "R7 done pulse", done, 1);
        chk(rd_n == NLD, "R3 read count", rd_n, NLD);
        chk(wr_n == NLD, "R4 write count", wr_n, NLD);
        chk(bz == NLD + 1, "R7 busy length", bz, NLD + 1);
        @(negedge clk);
        chk(!done && !busy && !mem_rd, "R8 no restart after load",
            {done, busy, mem_rd}, 0);
    endtask

    task automatic run_bad(input int i, input int j);
        @(negedge clk);
        start = 1'b1; org_row = 3'(i); org_col = 4'(j);
        @(negedge clk);
        start = 1'b0;
        chk(align_err && !busy && !mem_rd, "R2 error pulse", {align_err, busy, mem_rd}, 3'b100);
        @(negedge clk);
        chk(!align_err && !busy && !mem_rd && !(|mod_we_row), "R2 single pulse, quiet",
            {align_err, busy, mem_rd}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!busy && !done && !align_err && !mem_rd && !(|mod_we_row) && !(|mod_we_col),
            "R1 reset state", {busy, done, align_err, mem_rd}, 0);
        run_load(0, 0, 0);
        run_load(M - A, N - B, 1);
        run_load(2, 4, 2);
        run_bad(1, 0);
        run_bad(0, 2);
        run_bad(3, 5);
        for (int n = 0; n < 20; n++) begin
            int i = int'($urandom_range(M / A - 1)) * A;
            int j = int'($urandom_range(NBC - 1)) * B;
            run_load(i, j, int'($urandom_range(2)));
            if ($urandom_range(3) == 0)
                run_bad(int'($urandom_range(M - 1)) | 1, int'($urandom_range(N - 1)));
        end
        for (int bi = 0; bi < M / A; bi++)
            for (int bj = 0; bj < NBC; bj++)
                run_load(bi * A, bj * B, 0);
        // R9 full array contents
        for (int p = 0; p < A; p++)
            for (int q = 0; q < B; q++)
                for (int L = 0; L < NLA; L++)
                    chk(mm[p][q][L] === pix((L / NBC) * A + p, (L % NBC) * B + q),
                        "R9 module contents", mm[p][q][L],
                        pix((L / NBC) * A + p, (L % NBC) * B + q));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule